// File: doc/BRIEF.md
# Subroutine Call-Return Register Stacks

This block keeps the program counter and the instance base register of a small stack-oriented control virtual machine. It also holds two hardware stacks that save those registers across subroutine calls. A call command carries the first instruction address of the subroutine and the address of the instance it runs on. In one clock the block saves the caller's program counter and base register on their own stacks and loads the new values. A return command pops both stacks together and restores the caller's context. Because the stacks save the caller's base, nested function-block instances can keep relocatable local variables.

A sequential-advance command lets the surrounding decoder move the program counter between calls. A combinational helper forms absolute operand addresses. It adds the current base to a relative operand address, or uses no base for a global operand. When a call meets full stacks, or a return meets empty stacks, nothing changes and a status pulse is raised.

Top module: `crs_call_unit`

## Requirements
- R1: A synchronous active-high reset sets the program counter, the base register and the stack depth to zero and clears both status pulses.
- R2: An accepted call (call_valid high, ret_valid low, depth below DEPTH) saves the current program counter and base register and loads call_target and call_inst into them. It raises depth by one. All of this is visible after the next rising edge.
- R3: An accepted return (ret_valid high, depth above zero) restores the program counter and base register in last-in first-out order from the values saved by the matching call. It lowers depth by one.
- R4: A return while depth is zero leaves both registers and depth unchanged. The underflow output is high for exactly the cycle after that edge.
- R5: A call while depth equals DEPTH leaves both registers and depth unchanged. The overflow output is high for exactly the cycle after that edge.
- R6: When call_valid and ret_valid are both high, only the return is carried out and the call is ignored.
- R7: abs_addr equals rel_addr plus base_reg, modulo 2^ADDR_W, when global_sel is low. It equals rel_addr when global_sel is high. It is combinational.
- R8: With seq_valid high and neither call nor return requested, the program counter takes seq_target while the base register and depth hold. seq_valid is ignored in a cycle with a call or a return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| call_valid | input | 1 | Call request strobe |
| call_target | input | ADDR_W | First instruction address of the subroutine |
| call_inst | input | ADDR_W | Instance base address for the subroutine |
| ret_valid | input | 1 | Return request strobe, wins over a call |
| seq_valid | input | 1 | Sequential program counter update strobe |
| seq_target | input | ADDR_W | New program counter for a sequential update |
| rel_addr | input | ADDR_W | Relative operand address |
| global_sel | input | 1 | Operand is global: no base is added |
| code_reg | output | ADDR_W | Program counter |
| base_reg | output | ADDR_W | Instance base register |
| depth | output | $clog2(DEPTH+1) | Number of saved contexts |
| abs_addr | output | ADDR_W | Absolute operand address |
| overflow | output | 1 | Pulse: call rejected on full stacks |
| underflow | output | 1 | Pulse: return rejected on empty stacks |

## Verification
The bench builds the block with ADDR_W of 32 and DEPTH of 4. This shallow depth means a handful of calls fills the stacks, so the overflow rejection and the return of all four saved contexts in reverse order both fall within a short run. Keeping the full address width lets the operand adder be driven across a carry out of the top bit, which checks the modulo wrap. A reset issued with contexts still saved shows that stale entries do not come back after reset.

// File: rtl/crs_pkg.sv
package crs_pkg;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_SEQ  = 2'd1,
        OP_CALL = 2'd2,
        OP_RET  = 2'd3
    } crs_op_e;

    typedef struct packed {
        crs_op_e op;
        logic    ovf;
        logic    unf;
    } crs_dec_t;

    // Return first, then call, then sequential update.
    function automatic crs_dec_t crs_resolve(
        input logic call_v,
        input logic ret_v,
        input logic seq_v,
        input logic full,
        input logic empty
    );
        crs_dec_t d;
        d.op  = OP_IDLE;
        d.ovf = 1'b0;
        d.unf = 1'b0;
        if (ret_v) begin
            if (empty) d.unf = 1'b1;
            else       d.op  = OP_RET;
        end else if (call_v) begin
            if (full) d.ovf = 1'b1;
            else      d.op  = OP_CALL;
        end else if (seq_v) begin
            d.op = OP_SEQ;
        end
        return d;
    endfunction

endpackage

// File: rtl/crs_lifo.sv
module crs_lifo #(
    parameter int W     = 32,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  logic                       pop,
    input  logic [W-1:0]               wdata,
    output logic [W-1:0]               top,
    output logic [$clog2(DEPTH+1)-1:0] cnt,
    output logic                       full,
    output logic                       empty
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH+1);

    logic [W-1:0]     mem [DEPTH];
    logic [CNT_W-1:0] ptr;
    logic [CNT_W-1:0] ptr_dec;

    assign ptr_dec = ptr - CNT_W'(1);
    assign full    = (ptr == CNT_W'(DEPTH));
    assign empty   = (ptr == '0);
    assign cnt     = ptr;
    assign top     = empty ? '0 : mem[ptr_dec[IDX_W-1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (push && !full) begin
            ptr <= ptr + CNT_W'(1);
        end else if (pop && !empty) begin
            ptr <= ptr_dec;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && push && !full) begin
            mem[ptr[IDX_W-1:0]] <= wdata;
        end
    end
endmodule

// File: rtl/crs_arbiter.sv
module crs_arbiter
    import crs_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    call_valid,
    input  logic    ret_valid,
    input  logic    seq_valid,
    input  logic    full,
    input  logic    empty,
    output crs_op_e op,
    output logic    overflow,
    output logic    underflow
);
    crs_dec_t dec;

    assign dec = crs_resolve(call_valid, ret_valid, seq_valid, full, empty);
    assign op  = dec.op;

    always_ff @(posedge clk) begin
        if (rst) begin
            overflow  <= 1'b0;
            underflow <= 1'b0;
        end else begin
            overflow  <= dec.ovf;
            underflow <= dec.unf;
        end
    end
endmodule

// File: rtl/crs_regfile.sv
module crs_regfile
    import crs_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  crs_op_e           op,
    input  logic [ADDR_W-1:0] call_target,
    input  logic [ADDR_W-1:0] call_inst,
    input  logic [ADDR_W-1:0] seq_target,
    input  logic [ADDR_W-1:0] saved_code,
    input  logic [ADDR_W-1:0] saved_base,
    output logic [ADDR_W-1:0] code_reg,
    output logic [ADDR_W-1:0] base_reg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            code_reg <= '0;
            base_reg <= '0;
        end else begin
            unique case (op)
                OP_CALL: begin
                    code_reg <= call_target;
                    base_reg <= call_inst;
                end
                OP_RET: begin
                    code_reg <= saved_code;
                    base_reg <= saved_base;
                end
                OP_SEQ:  code_reg <= seq_target;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/crs_addr_gen.sv
module crs_addr_gen #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] rel_addr,
    input  logic [ADDR_W-1:0] base,
    input  logic              global_sel,
    output logic [ADDR_W-1:0] abs_addr
);
    logic [ADDR_W-1:0] offs;

    assign offs     = global_sel ? '0 : base;
    assign abs_addr = rel_addr + offs;
endmodule

// File: rtl/crs_call_unit.sv
module crs_call_unit
    import crs_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       call_valid,
    input  logic [ADDR_W-1:0]          call_target,
    input  logic [ADDR_W-1:0]          call_inst,
    input  logic                       ret_valid,
    input  logic                       seq_valid,
    input  logic [ADDR_W-1:0]          seq_target,
    input  logic [ADDR_W-1:0]          rel_addr,
    input  logic                       global_sel,
    output logic [ADDR_W-1:0]          code_reg,
    output logic [ADDR_W-1:0]          base_reg,
    output logic [$clog2(DEPTH+1)-1:0] depth,
    output logic [ADDR_W-1:0]          abs_addr,
    output logic                       overflow,
    output logic                       underflow
);
    localparam int CNT_W = $clog2(DEPTH+1);

    crs_op_e           op;
    logic              push, pop;
    logic              code_full, code_empty, base_full, base_empty;
    logic [ADDR_W-1:0] code_top, base_top;
    logic [CNT_W-1:0]  code_cnt, base_cnt;

    assign push  = (op == OP_CALL);
    assign pop   = (op == OP_RET);
    assign depth = code_cnt;

    crs_arbiter arb_i (
        .clk        (clk),
        .rst        (rst),
        .call_valid (call_valid),
        .ret_valid  (ret_valid),
        .seq_valid  (seq_valid),
        .full       (code_full | base_full),
        .empty      (code_empty | base_empty),
        .op         (op),
        .overflow   (overflow),
        .underflow  (underflow)
    );

    crs_lifo #(.W(ADDR_W), .DEPTH(DEPTH)) code_stk_i (
        .clk   (clk),
        .rst   (rst),
        .push  (push),
        .pop   (pop),
        .wdata (code_reg),
        .top   (code_top),
        .cnt   (code_cnt),
        .full  (code_full),
        .empty (code_empty)
    );

    crs_lifo #(.W(ADDR_W), .DEPTH(DEPTH)) base_stk_i (
        .clk   (clk),
        .rst   (rst),
        .push  (push),
        .pop   (pop),
        .wdata (base_reg),
        .top   (base_top),
        .cnt   (base_cnt),
        .full  (base_full),
        .empty (base_empty)
    );

    crs_regfile #(.ADDR_W(ADDR_W)) regs_i (
        .clk         (clk),
        .rst         (rst),
        .op          (op),
        .call_target (call_target),
        .call_inst   (call_inst),
        .seq_target  (seq_target),
        .saved_code  (code_top),
        .saved_base  (base_top),
        .code_reg    (code_reg),
        .base_reg    (base_reg)
    );

    crs_addr_gen #(.ADDR_W(ADDR_W)) agen_i (
        .rel_addr   (rel_addr),
        .base       (base_reg),
        .global_sel (global_sel),
        .abs_addr   (abs_addr)
    );
endmodule

// File: rtl/crs_call_chk.sv
module crs_call_chk #(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 16
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       call_valid,
    input logic                       ret_valid,
    input logic                       seq_valid,
    input logic [ADDR_W-1:0]          call_target,
    input logic [ADDR_W-1:0]          call_inst,
    input logic [ADDR_W-1:0]          code_reg,
    input logic [ADDR_W-1:0]          base_reg,
    input logic [$clog2(DEPTH+1)-1:0] depth,
    input logic                       overflow,
    input logic                       underflow,
    input logic [ADDR_W-1:0]          code_top,
    input logic [ADDR_W-1:0]          base_top,
    input logic [$clog2(DEPTH+1)-1:0] code_cnt,
    input logic [$clog2(DEPTH+1)-1:0] base_cnt
);
    localparam int CNT_W = $clog2(DEPTH+1);

    a_r1_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(overflow && underflow));

    a_r2_stacks_lockstep: assert property (@(posedge clk) disable iff (rst)
        code_cnt == base_cnt);

    a_r2_call_loads: assert property (@(posedge clk) disable iff (rst)
        (call_valid && !ret_valid && depth != CNT_W'(DEPTH))
        |=> (code_reg == $past(call_target)) && (base_reg == $past(call_inst))
            && (depth == $past(depth) + CNT_W'(1)));

    a_r3_ret_restores: assert property (@(posedge clk) disable iff (rst)
        (ret_valid && depth != '0)
        |=> (code_reg == $past(code_top)) && (base_reg == $past(base_top))
            && (depth == $past(depth) - CNT_W'(1)));

    a_r4_underflow: assert property (@(posedge clk) disable iff (rst)
        (ret_valid && depth == '0)
        |=> underflow && $stable(code_reg) && $stable(base_reg) && depth == '0);

    a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (call_valid && !ret_valid && depth == CNT_W'(DEPTH))
        |=> overflow && $stable(code_reg) && $stable(base_reg) && $stable(depth));

    a_r8_seq_keeps_base: assert property (@(posedge clk) disable iff (rst)
        (seq_valid && !call_valid && !ret_valid)
        |=> $stable(base_reg) && $stable(depth));
endmodule

bind crs_call_unit crs_call_chk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .call_valid  (call_valid),
    .ret_valid   (ret_valid),
    .seq_valid   (seq_valid),
    .call_target (call_target),
    .call_inst   (call_inst),
    .code_reg    (code_reg),
    .base_reg    (base_reg),
    .depth       (depth),
    .overflow    (overflow),
    .underflow   (underflow),
    .code_top    (code_top),
    .base_top    (base_top),
    .code_cnt    (code_cnt),
    .base_cnt    (base_cnt)
);

// File: tb/crs_call_unit_tb_top.sv
module crs_call_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW         = 32;
    localparam int DP         = 4;
    localparam int CW         = $clog2(DP+1);

    logic          clk = 1'b0;
    logic          rst;
    logic          call_valid, ret_valid, seq_valid, global_sel;
    logic [AW-1:0] call_target, call_inst, seq_target, rel_addr;
    logic [AW-1:0] code_reg, base_reg, abs_addr;
    logic [CW-1:0] depth;
    logic          overflow, underflow;

    always #(CLK_PERIOD/2) clk = ~clk;

    crs_call_unit #(.ADDR_W(AW), .DEPTH(DP)) dut_i (
        .clk(clk), .rst(rst),
        .call_valid(call_valid), .call_target(call_target), .call_inst(call_inst),
        .ret_valid(ret_valid), .seq_valid(seq_valid), .seq_target(seq_target),
        .rel_addr(rel_addr), .global_sel(global_sel),
        .code_reg(code_reg), .base_reg(base_reg), .depth(depth),
        .abs_addr(abs_addr), .overflow(overflow), .underflow(underflow)
    );

    typedef struct {
        logic [AW-1:0] code;
        logic [AW-1:0] base;
        int            dep;
        logic          ovf;
        logic          unf;
        string         req;
    } exp_t;

    exp_t          sb[$];
    int            n_chk = 0;
    int            n_bad = 0;
    bit            done  = 0;
    logic [AW-1:0] m_code, m_base;
    logic [AW-1:0] m_cstk[$];
    logic [AW-1:0] m_bstk[$];

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    // Monitor: compare registered outputs at the falling edge.
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_chk++;
            if (code_reg !== e.code || base_reg !== e.base || int'(depth) != e.dep
                || overflow !== e.ovf || underflow !== e.unf) begin
                n_bad++;
                $display("FAIL %s: got code=%h base=%h depth=%0d ovf=%b unf=%b, want code=%h base=%h depth=%0d ovf=%b unf=%b",
                         e.req, code_reg, base_reg, depth, overflow, underflow,
                         e.code, e.base, e.dep, e.ovf, e.unf);
            end
        end
    end

    task automatic push_exp(input logic o, input logic u, input string req);
        exp_t e;
        e.code = m_code; e.base = m_base; e.dep = m_cstk.size();
        e.ovf = o; e.unf = u; e.req = req;
        sb.push_back(e);
    endtask

    task automatic do_reset(input string req);
        @(negedge clk);
        rst = 1'b1;
        call_valid = 0; ret_valid = 0; seq_valid = 0;
        @(posedge clk); @(posedge clk); #1;
        rst = 1'b0;
        m_code = '0; m_base = '0;
        m_cstk.delete(); m_bstk.delete();
        push_exp(1'b0, 1'b0, req);
    endtask

    // Driver: apply one command, update the model, queue the expectation.
    task automatic drive(input logic cv, input logic rv, input logic sv,
                         input logic [AW-1:0] tgt, input logic [AW-1:0] inst,
                         input logic [AW-1:0] sq, input string req);
        logic o, u;
        @(negedge clk);
        call_valid = cv; ret_valid = rv; seq_valid = sv;
        call_target = tgt; call_inst = inst; seq_target = sq;
        @(posedge clk); #1;
        call_valid = 0; ret_valid = 0; seq_valid = 0;
        o = 0; u = 0;
        if (rv) begin
            if (m_cstk.size() == 0) u = 1;
            else begin
                m_code = m_cstk.pop_back();
                m_base = m_bstk.pop_back();
            end
        end else if (cv) begin
            if (m_cstk.size() == DP) o = 1;
            else begin
                m_cstk.push_back(m_code);
                m_bstk.push_back(m_base);
                m_code = tgt; m_base = inst;
            end
        end else if (sv) begin
            m_code = sq;
        end
        push_exp(o, u, req);
    endtask

    task automatic check_abs(input logic [AW-1:0] rel, input logic g);
        logic [AW-1:0] want;
        @(negedge clk);
        rel_addr = rel; global_sel = g;
        #1;
        want = g ? rel : rel + m_base;
        n_chk++;
        if (abs_addr !== want) begin
            n_bad++;
            $display("FAIL R7: abs_addr got %h want %h (rel=%h global=%b)", abs_addr, want, rel, g);
        end
    endtask

    initial begin
        #(CLK_PERIOD*20000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not end, got timeout want completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; call_valid = 0; ret_valid = 0; seq_valid = 0;
        call_target = '0; call_inst = '0; seq_target = '0;
        rel_addr = '0; global_sel = 0;
        do_reset("R1 reset state");

        drive(0, 0, 1, 0, 0, 32'h0000_0100, "R8 seq update");
        drive(1, 0, 0, 32'h0000_2000, 32'h0000_0040, 0, "R2 first call");
        drive(0, 0, 1, 0, 0, 32'h0000_2004, "R8 seq inside callee");
        drive(1, 0, 0, 32'h0000_3000, 32'h0000_0080, 0, "R2 nested call");
        check_abs(32'h0000_0010, 1'b0);
        check_abs(32'h0000_0010, 1'b1);
        check_abs(32'hFFFF_FFF0, 1'b0);
        drive(0, 1, 0, 0, 0, 0, "R3 return to first callee");
        drive(0, 1, 0, 0, 0, 0, "R3 return to top level");
        drive(0, 1, 0, 0, 0, 0, "R4 return on empty");
        drive(0, 0, 0, 0, 0, 0, "R4 underflow pulse clears");

        for (int i = 0; i < DP; i++) begin
            drive(1, 0, 0, 32'h0001_0000 + AW'(i*16), 32'h0000_1000 + AW'(i*256), 0, "R2 fill");
        end
        drive(1, 0, 0, 32'hDEAD_0000, 32'hBEEF_0000, 0, "R5 call on full");
        drive(0, 0, 0, 0, 0, 0, "R5 overflow pulse clears");
        drive(1, 1, 0, 32'h0BAD_0000, 32'h0BAD_0001, 0, "R6 return beats call");
        drive(1, 0, 1, 32'h0002_0000, 32'h0000_2222, 32'h0000_7777, "R8 seq ignored under call");
        drive(0, 1, 1, 0, 0, 32'h0000_8888, "R8 seq ignored under return");
        check_abs(32'h0000_0004, 1'b0);
        for (int i = 0; i < DP; i++) begin
            drive(0, 1, 0, 0, 0, 0, "R3 unwind in reverse order");
        end
        drive(0, 1, 0, 0, 0, 0, "R4 second empty return");

        drive(1, 0, 0, 32'h0000_4000, 32'h0000_0400, 0, "R2 call before reset");
        drive(1, 0, 0, 32'h0000_5000, 32'h0000_0500, 0, "R2 call before reset");
        do_reset("R1 reset with saved contexts");
        drive(0, 1, 0, 0, 0, 0, "R1 stacks empty after reset");

        @(negedge clk); @(negedge clk);
        finish_run();
    end
endmodule